// File: doc/BRIEF.md
# Wave Sample Memory Access Arbiter

This block holds the sample table of a wave playback channel: a small byte memory in which every byte packs two samples. The processor reaches the table through a window of consecutive byte addresses. The playback engine supplies its current sample position, a flag that says the channel is running, and a flag that says the processor may currently touch the memory.

When the channel is idle, processor reads and writes reach the addressed byte. While the channel runs, the address the processor gives is ignored. If the access flag is set, the access goes to the byte under the playback position. If the flag is clear, reads return all ones and writes are discarded. Each cycle the block also registers the sample nibble under the playback position for the playback side. Generating the sample timing and scaling the volume belong to the playback engine.

Top module: `wave_ram_arb`

## Requirements
- R1: The memory has 2**ADDR_W bytes (16 by default). `cpu_addr` selects byte 0 to 15. Each byte holds two NIB_W-bit samples, so play_pos covers 32 sample positions.
- R2: While `play_on` is 0, `cpu_rdata` shows the byte at `cpu_addr` in the same cycle. A write with `cpu_wr`=1 stores `cpu_wdata` there at the clock edge.
- R3: While `play_on`=1 and `play_rd_ok`=1, reads and writes use the byte at index `play_pos[4:1]`, and `cpu_addr` is ignored.
- R4: While `play_on`=1 and `play_rd_ok`=0, `cpu_rdata` is 0xFF.
- R5: While `play_on`=1 and `play_rd_ok`=0, a write leaves every byte unchanged.
- R6: One clock edge after the inputs are presented, `samp_nib` holds a nibble of the byte at `play_pos[4:1]`. It is bits [7:4] when `play_pos[0]`=0 and bits [3:0] when `play_pos[0]`=1 (HI_FIRST=1). This happens whether or not the channel plays.
- R7: If a write hits the byte being fetched at the same edge, `samp_nib` takes that byte's value from before the write.
- R8: While `rst_n` is low, `samp_nib` is 0. Reset does not change the memory contents.
- R9: No byte changes in a cycle where `cpu_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sample register |
| cpu_addr | input | 4 | Processor byte index inside the window |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data (combinational) |
| play_on | input | 1 | Channel is playing |
| play_rd_ok | input | 1 | Processor may touch memory during playback |
| play_pos | input | 5 | Current sample position |
| samp_nib | output | 4 | Registered sample for the playback side |

## Verification
A wrong redirect decision appears on `cpu_rdata` in the same cycle, because the read path has no register. A dropped write or a write to the wrong byte stays hidden until that byte is read back or fetched by playback, so the bench reads back and walks all positions after each phase. A wrong nibble order or a fetch that sees the new byte shows on `samp_nib` one edge after the cause. A reset that clears the memory shows on the first readback after reset.

// File: rtl/wave_ram_pkg.sv
package wave_ram_pkg;
   typedef enum logic [1:0] {
      ACC_DIRECT = 2'd0,
      ACC_FOLLOW = 2'd1,
      ACC_LOCKED = 2'd2
   } acc_mode_e;
endpackage

// File: rtl/wave_ram_route.sv
module wave_ram_route
   import wave_ram_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              play_on,
   input  logic              play_rd_ok,
   input  logic [ADDR_W:0]   play_pos,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   output acc_mode_e         mode,
   output logic [ADDR_W-1:0] eff_idx,
   output logic              wr_en
);
   always_comb begin
      if (!play_on)        mode = ACC_DIRECT;
      else if (play_rd_ok) mode = ACC_FOLLOW;
      else                 mode = ACC_LOCKED;
   end

   // playback position selects a byte by dropping its nibble bit
   assign eff_idx = (mode == ACC_DIRECT) ? cpu_addr : play_pos[ADDR_W:1];
   assign wr_en   = cpu_wr && (mode != ACC_LOCKED);
endmodule

// File: rtl/wave_ram_store.sv
module wave_ram_store #(
   parameter int ADDR_W = 4,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] cpu_idx,
   input  logic [ADDR_W-1:0] play_idx,
   output logic [BYTE_W-1:0] cpu_byte,
   output logic [BYTE_W-1:0] play_byte
);
   localparam int DEPTH = 2 ** ADDR_W;

   logic [BYTE_W-1:0] mem [DEPTH];

   // contents deliberately survive reset
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign cpu_byte  = mem[cpu_idx];
   assign play_byte = mem[play_idx];
endmodule

// File: rtl/wave_ram_pick.sv
module wave_ram_pick #(
   parameter int NIB_W    = 4,
   parameter int HI_FIRST = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*NIB_W-1:0] byte_in,
   input  logic               odd,
   output logic [NIB_W-1:0]   nib_q
);
   logic [NIB_W-1:0] nib_d;

   generate
      if (HI_FIRST != 0) begin : g_hi_first
         assign nib_d = odd ? byte_in[NIB_W-1:0] : byte_in[2*NIB_W-1:NIB_W];
      end else begin : g_lo_first
         assign nib_d = odd ? byte_in[2*NIB_W-1:NIB_W] : byte_in[NIB_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) nib_q <= '0;
      else        nib_q <= nib_d;
   end
endmodule

// File: rtl/wave_ram_arb.sv
module wave_ram_arb
   import wave_ram_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int NIB_W    = 4,
   parameter int HI_FIRST = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic                 cpu_wr,
   input  logic [2*NIB_W-1:0]   cpu_wdata,
   output logic [2*NIB_W-1:0]   cpu_rdata,
   input  logic                 play_on,
   input  logic                 play_rd_ok,
   input  logic [ADDR_W:0]      play_pos,
   output logic [NIB_W-1:0]     samp_nib
);
   localparam int BYTE_W = 2 * NIB_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("wave_ram_arb: ADDR_W out of range");
      end
      if (NIB_W < 1) begin : g_bad_nib
         $error("wave_ram_arb: NIB_W must be positive");
      end
   endgenerate

   acc_mode_e          mode;
   logic [ADDR_W-1:0]  eff_idx;
   logic               wr_en;
   logic [BYTE_W-1:0]  cpu_byte;
   logic [BYTE_W-1:0]  play_byte;

   wave_ram_route #(.ADDR_W(ADDR_W)) u_route (
      .play_on    (play_on),
      .play_rd_ok (play_rd_ok),
      .play_pos   (play_pos),
      .cpu_addr   (cpu_addr),
      .cpu_wr     (cpu_wr),
      .mode       (mode),
      .eff_idx    (eff_idx),
      .wr_en      (wr_en)
   );

   wave_ram_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_store (
      .clk       (clk),
      .wr_en     (wr_en),
      .wr_idx    (eff_idx),
      .wr_data   (cpu_wdata),
      .cpu_idx   (eff_idx),
      .play_idx  (play_pos[ADDR_W:1]),
      .cpu_byte  (cpu_byte),
      .play_byte (play_byte)
   );

   wave_ram_pick #(.NIB_W(NIB_W), .HI_FIRST(HI_FIRST)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_in (play_byte),
      .odd     (play_pos[0]),
      .nib_q   (samp_nib)
   );

   assign cpu_rdata = (mode == ACC_LOCKED) ? {BYTE_W{1'b1}} : cpu_byte;
endmodule

// File: rtl/wave_ram_chk.sv
module wave_ram_chk #(
   parameter int ADDR_W   = 4,
   parameter int NIB_W    = 4,
   parameter int HI_FIRST = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  cpu_addr,
   input logic               cpu_wr,
   input logic [2*NIB_W-1:0] cpu_wdata,
   input logic [2*NIB_W-1:0] cpu_rdata,
   input logic               play_on,
   input logic               play_rd_ok,
   input logic [ADDR_W:0]    play_pos,
   input logic [NIB_W-1:0]   samp_nib
);
   logic             sel_low;
   logic [NIB_W-1:0] exp_nib;
   logic             view_is_play;

   assign sel_low      = (play_pos[0] == (HI_FIRST != 0));
   assign exp_nib      = sel_low ? cpu_rdata[NIB_W-1:0] : cpu_rdata[2*NIB_W-1:NIB_W];
   assign view_is_play = (play_on && play_rd_ok) ||
                         (!play_on && cpu_addr == play_pos[ADDR_W:1]);

   // R4: locked playback reads all ones
   a_r4_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
      (play_on && !play_rd_ok) |-> (cpu_rdata == {2*NIB_W{1'b1}}));

   // R2: idle write is visible at the same address next cycle
   a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !play_on) ##1 (!play_on && cpu_addr == $past(cpu_addr))
      |-> (cpu_rdata == $past(cpu_wdata)));

   // R3: followed write lands on the byte under the playback position
   a_r3_follow_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && play_on && play_rd_ok) ##1
      (play_on && play_rd_ok && play_pos[ADDR_W:1] == $past(play_pos[ADDR_W:1]))
      |-> (cpu_rdata == $past(cpu_wdata)));

   // R6 and R7: registered sample equals the pre-edge byte's nibble
   a_r6_sample_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      view_is_play |=> (samp_nib == $past(exp_nib)));

   // R8: sample register is cleared by reset
   a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (samp_nib == '0));
endmodule

bind wave_ram_arb wave_ram_chk #(
   .ADDR_W(ADDR_W), .NIB_W(NIB_W), .HI_FIRST(HI_FIRST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_addr   (cpu_addr),
   .cpu_wr     (cpu_wr),
   .cpu_wdata  (cpu_wdata),
   .cpu_rdata  (cpu_rdata),
   .play_on    (play_on),
   .play_rd_ok (play_rd_ok),
   .play_pos   (play_pos),
   .samp_nib   (samp_nib)
);

// File: tb/wave_ram_arb_tb.sv
module wave_ram_arb_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cpu_addr = '0;
   logic       cpu_wr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       play_on = 1'b0;
   logic       play_rd_ok = 1'b0;
   logic [4:0] play_pos = '0;
   logic [3:0] samp_nib;

   int n_chk = 0;
   int n_bad = 0;
   int ref_mem [16];
   int ref_samp = 0;

   always #4 clk = ~clk;

   wave_ram_arb u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .play_on(play_on),
      .play_rd_ok(play_rd_ok), .play_pos(play_pos), .samp_nib(samp_nib)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one cycle: drive after negedge, check read, advance model at posedge, check sample
   task automatic step(input string tag, input bit chk, input bit rst, input bit we,
                       input int addr, input int wd, input bit pon, input bit rok,
                       input int pos);
      int idx;
      int exp_r;
      bit locked;
      rst_n = rst; cpu_wr = we; cpu_addr = addr[3:0]; cpu_wdata = wd[7:0];
      play_on = pon; play_rd_ok = rok; play_pos = pos[4:0];
      locked = pon && !rok;
      idx = pon ? (pos >> 1) : addr;
      #1;
      exp_r = locked ? 8'hFF : ref_mem[idx];
      if (chk) check(tag, "cpu_rdata", int'(cpu_rdata), exp_r);
      @(posedge clk);
      if (!rst) ref_samp = 0;
      else ref_samp = pos[0] ? (ref_mem[pos >> 1] & 15) : (ref_mem[pos >> 1] >> 4);
      if (we && !locked) ref_mem[idx] = wd & 255;
      @(negedge clk);
      if (chk) check(tag, "samp_nib", int'(samp_nib), ref_samp);
   endtask

   initial begin
      #(8 * 190000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      foreach (ref_mem[i]) ref_mem[i] = 0;
      @(negedge clk);
      // R8: reset holds sample at zero
      step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
      check("R8", "samp_nib in reset", int'(samp_nib), 0);
      // R1 R2: fill all 16 bytes while idle, no checks (contents unknown)
      for (int i = 0; i < 16; i++) step("R1", 0, 1, 1, i, (i * 8'h11) ^ 8'hA5, 0, 0, 30);
      // R1 R2: readback, with play_pos walking to test R6
      for (int i = 0; i < 16; i++) step("R2", 1, 1, 0, i, 0, 0, 0, 2 * i + (i & 1));
      // R6: walk all sample positions while playing
      for (int p = 0; p < 32; p++) step("R6", 1, 1, 0, p & 15, 0, 1, 1, p);
      // R3: address ignored, writes redirected
      step("R3", 1, 1, 1, 2, 8'h3C, 1, 1, 19);
      step("R3", 1, 1, 0, 0, 0, 1, 1, 18);
      step("R3", 1, 1, 0, 9, 0, 0, 0, 0);
      step("R3", 1, 1, 0, 2, 0, 0, 0, 0);
      // R4 R5: locked reads and dropped writes
      step("R4", 1, 1, 0, 5, 0, 1, 0, 10);
      step("R5", 1, 1, 1, 5, 8'h00, 1, 0, 10);
      step("R5", 1, 1, 1, 7, 8'h00, 1, 0, 14);
      step("R5", 1, 1, 0, 5, 0, 0, 0, 0);
      step("R5", 1, 1, 0, 7, 0, 0, 0, 0);
      // R9: data without strobe changes nothing
      step("R9", 1, 1, 0, 4, 8'h77, 0, 0, 8);
      step("R9", 1, 1, 0, 4, 0, 0, 0, 8);
      // R7: same-edge write and fetch of one byte
      step("R7", 1, 1, 1, 6, 8'hE1, 0, 0, 12);
      step("R7", 1, 1, 0, 6, 0, 0, 0, 12);
      step("R7", 1, 1, 1, 0, 8'h5B, 1, 1, 13);
      step("R7", 1, 1, 0, 0, 0, 1, 1, 13);
      // R8: reset keeps memory
      step("R8", 1, 0, 0, 3, 0, 0, 0, 6);
      step("R8", 1, 0, 0, 3, 0, 0, 0, 6);
      for (int i = 0; i < 16; i++) step("R8", 1, 1, 0, i, 0, 0, 0, 31 - i);
      // mixed traffic covering every requirement path
      for (int k = 0; k < 400; k++) begin
         int r;
         r = int'($urandom);
         step("R3", 1, 1, r[0], (r >> 1) & 15, (r >> 5) & 255, r[13], r[14] | r[15],
              (r >> 16) & 31);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule